// File: doc/BRIEF.md
# Bus-Master Time-Slice Timer

This block limits how long a bus-master function may keep a PCI-style bus once the system has asked for it back. Software programs an 8-bit latency value, of which only the upper four bits count, so the limit comes in steps of 16 bus clocks. A counter runs while the function drives the frame signal and is cleared whenever it does not.

While hold-acknowledge (active low) stays asserted, the master may run back-to-back transactions without any limit. Once hold-acknowledge is seen negated during a frame, enforcement latches until that frame ends. When the count then reaches the programmed value, a sticky expired flag rises. The master state machine receives a request to end the burst at the completion strobe of the transfer in flight, so it releases the bus only after that transfer has finished.

Top module: `bus_slice_timer`

## Requirements
- R1: After reset the readback value is 00h, and both the expired flag and the end-burst request are low.
- R2: A register write stores bits 7:4 of the written data. Readback from the next cycle on returns those bits, with bits 3:0 always read as zero.
- R3: The elapsed-clock counter is cleared in every cycle in which the frame signal is not driven, so a new frame starts counting from zero.
- R4: While frame is driven, the counter advances by one per clock. With enforcement latched from the first frame edge and a limit of L (L > 0), the expired flag is first high in frame cycle L+2, where frame cycle 1 is the first cycle with frame high.
- R5: While hold-acknowledge stays low (active) for a whole frame, the expired flag never rises, whatever the count.
- R6: A high (negated) hold-acknowledge sampled at a rising edge during a frame latches enforcement. The latch holds until frame is dropped, even if hold-acknowledge goes low again.
- R7: Once set, the expired flag stays high for as long as frame is driven, and it clears in the cycle after frame is dropped.
- R8: End-burst request is high only in a cycle where the expired flag, frame and the transfer-complete strobe are all high. A completion strobe before expiry has no effect.
- R9: A limit of zero expires at the first edge after enforcement has latched.
- R10: The counter saturates at its maximum value instead of wrapping, so a frame longer than 255 clocks still meets a limit of F0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Latency register write strobe |
| regWrData | input | 8 | Write data for the latency register |
| regRdData | output | 8 | Latency register readback |
| frameOwned | input | 1 | High while this function drives the frame signal |
| holdAckN | input | 1 | Hold-acknowledge, active low |
| xferDone | input | 1 | One-cycle strobe when the current transfer completes |
| sliceExpired | output | 1 | Sticky flag: the time slice is used up |
| endBurstReq | output | 1 | Request to release the bus after this transfer |

## Verification
The bench programs a limit of zero and checks that expiry follows immediately once enforcement latches. A design that compared for equality after a first increment would wait for the counter to wrap. In a frame longer than 256 clocks, hold-acknowledge is negated late. A counter that wraps would then sit below F0h and fail to expire. Hold-acknowledge is pulsed negated for a single cycle and then returned low. A design that followed the live level instead of latching would never expire. The bench also checks early completion strobes, and a short gap in frame that must restart the count. A counter that is not cleared would expire too soon.

// File: rtl/slice_pkg.sv
package slice_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_LIMITED,
    ST_EXPIRED
  } slice_state_e;

  typedef struct packed {
    logic latWr;
    logic cntClr;
    logic cntEn;
  } slice_strobe_t;

endpackage

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int RSV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  slice_strobe_t    strobe,
  input  logic [LAT_W-1:0] wrData,
  output logic [LAT_W-1:0] rdData,
  output logic             limitReached
);
  localparam int HI_W = LAT_W - RSV_W;

  logic [HI_W-1:0]  latHi;
  logic [LAT_W-1:0] latFull;
  logic [LAT_W-1:0] elapsed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latHi <= '0;
    else if (strobe.latWr) latHi <= wrData[LAT_W-1:RSV_W];
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      logic unusedLowBits;
      assign unusedLowBits = ^wrData[RSV_W-1:0];
      assign latFull = {latHi, {RSV_W{1'b0}}};
    end else begin : g_norsv
      assign latFull = latHi;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) elapsed <= '0;
    else if (strobe.cntClr) elapsed <= '0;
    else if (strobe.cntEn && (elapsed != {LAT_W{1'b1}})) elapsed <= elapsed + 1'b1;
  end

  assign rdData       = latFull;
  assign limitReached = (elapsed >= latFull);
endmodule

// File: rtl/slice_control.sv
module slice_control
  import slice_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameOwned,
  input  logic          holdAckN,
  input  logic          xferDone,
  input  logic          regWrEn,
  input  logic          limitReached,
  output slice_strobe_t strobe,
  output slice_state_e  state,
  output logic          sliceExpired,
  output logic          endBurstReq
);
  slice_state_e nextState;

  always_comb begin
    nextState = state;
    if (!frameOwned) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    nextState = holdAckN ? ST_LIMITED : ST_OPEN;
        ST_OPEN:    if (holdAckN) nextState = ST_LIMITED;
        ST_LIMITED: if (limitReached) nextState = ST_EXPIRED;
        ST_EXPIRED: nextState = ST_EXPIRED;
        default:    nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    strobe.latWr  = regWrEn;
    strobe.cntClr = !frameOwned;
    strobe.cntEn  = frameOwned;
  end

  assign sliceExpired = (state == ST_EXPIRED);
  assign endBurstReq  = sliceExpired && frameOwned && xferDone;
endmodule

// File: rtl/bus_slice_timer.sv
module bus_slice_timer
  import slice_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int RSV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [LAT_W-1:0] regWrData,
  output logic [LAT_W-1:0] regRdData,
  input  logic             frameOwned,
  input  logic             holdAckN,
  input  logic             xferDone,
  output logic             sliceExpired,
  output logic             endBurstReq
);
  slice_strobe_t strobe;
  slice_state_e  ctlState;
  logic          limitReached;

  slice_control u_ctl (
    .clk(clk), .rstN(rstN), .frameOwned(frameOwned), .holdAckN(holdAckN),
    .xferDone(xferDone), .regWrEn(regWrEn), .limitReached(limitReached),
    .strobe(strobe), .state(ctlState), .sliceExpired(sliceExpired),
    .endBurstReq(endBurstReq)
  );

  slice_datapath #(.LAT_W(LAT_W), .RSV_W(RSV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .rdData(regRdData), .limitReached(limitReached)
  );
endmodule

// File: rtl/slice_checker.sv
module slice_checker
  import slice_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         regWrEn,
  input logic [7:0]   regWrData,
  input logic [7:0]   regRdData,
  input logic         frameOwned,
  input logic         holdAckN,
  input logic         xferDone,
  input logic         sliceExpired,
  input logic         endBurstReq,
  input slice_state_e ctlState
);
  p_low_nibble_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[3:0] == 4'h0);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData[7:4] == $past(regWrData[7:4]));

  p_idle_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    !frameOwned |=> !sliceExpired);

  p_open_no_expiry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_OPEN && !holdAckN) |=> !sliceExpired);

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameOwned && ctlState == ST_LIMITED) |=> (ctlState == ST_LIMITED || sliceExpired));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sliceExpired && frameOwned) |=> sliceExpired);

  p_end_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    endBurstReq |-> (xferDone && sliceExpired && frameOwned));
endmodule

bind bus_slice_timer slice_checker u_chk (.*);

// File: tb/tb_bus_slice_timer.sv
`timescale 1ns/1ps
module tb_bus_slice_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic frameOwned = 1'b0;
  logic holdAckN = 1'b0;
  logic xferDone = 1'b0;
  logic sliceExpired;
  logic endBurstReq;

  always #2.5 clk = ~clk;

  bus_slice_timer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .frameOwned(frameOwned), .holdAckN(holdAckN),
    .xferDone(xferDone), .sliceExpired(sliceExpired), .endBurstReq(endBurstReq)
  );

  typedef struct {
    logic [7:0] rd;
    logic       exp;
    logic       fin;
    string      tag;
  } expect_t;

  expect_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // requirement-level reference state
  logic [7:0] mLat = 8'h00;
  int         mCnt = 0;
  bit         mEnf = 0;
  bit         mExp = 0;

  task automatic step(input logic f, input logic h, input logic d,
                      input logic w, input logic [7:0] wd, input string tag);
    expect_t e;
    @(negedge clk);
    frameOwned = f; holdAckN = h; xferDone = d; regWrEn = w; regWrData = wd;
    #1;
    e.rd = mLat; e.exp = mExp; e.fin = mExp && d && f; e.tag = tag;
    sb.push_back(e);
    if (!rstN) begin
      mLat = 8'h00; mCnt = 0; mEnf = 0; mExp = 0;
    end else begin
      bit nExp, nEnf;
      if (!f) begin
        nExp = 0; nEnf = 0; mCnt = 0;
      end else begin
        nExp = mExp || (mEnf && (mCnt >= int'(mLat)));
        nEnf = mEnf || h;
        if (mCnt < 255) mCnt = mCnt + 1;
      end
      mExp = nExp; mEnf = nEnf;
      if (w) mLat = {wd[7:4], 4'h0};
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic prog(input logic [7:0] v, input string tag);
    step(0, 0, 0, 1, v, tag);
    step(0, 0, 0, 0, 8'h00, tag);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        expect_t e;
        e = sb.pop_front();
        checks++;
        if (regRdData !== e.rd) begin
          failures++;
          $display("FAIL %s readback actual=%h expected=%h", e.tag, regRdData, e.rd);
        end
        checks++;
        if (sliceExpired !== e.exp) begin
          failures++;
          $display("FAIL %s expired actual=%b expected=%b", e.tag, sliceExpired, e.exp);
        end
        checks++;
        if (endBurstReq !== e.fin) begin
          failures++;
          $display("FAIL %s endBurst actual=%b expected=%b", e.tag, endBurstReq, e.fin);
        end
      end
    end
  end

  // watchdog
  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'h00, "R1");
    @(negedge clk); rstN = 1'b1;
    idle(2, "R1");

    // R2: high nibble kept, low nibble reads zero
    prog(8'hA7, "R2");
    prog(8'h3F, "R2");

    // R4 / R7 / R8: limit 10h, enforced from start
    prog(8'h10, "R4");
    for (int i = 1; i <= 24; i++) step(1, 1, 0, 0, 8'h00, "R4");
    step(1, 0, 1, 0, 8'h00, "R8");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 8'h00, "R7");
    idle(2, "R7");

    // R8: early completion before expiry does nothing
    prog(8'h30, "R8");
    for (int i = 1; i <= 10; i++) step(1, 1, (i == 5), 0, 8'h00, "R8");
    idle(2, "R8");

    // R5: hold-ack active all frame, never limited
    prog(8'h10, "R5");
    for (int i = 1; i <= 60; i++) step(1, 0, (i % 8 == 0), 0, 8'h00, "R5");
    idle(2, "R5");

    // R6: one-cycle negation latches enforcement
    prog(8'h20, "R6");
    for (int i = 1; i <= 10; i++) step(1, 0, 0, 0, 8'h00, "R6");
    step(1, 1, 0, 0, 8'h00, "R6");
    for (int i = 1; i <= 40; i++) step(1, 0, (i == 38), 0, 8'h00, "R6");
    idle(2, "R6");

    // R9: zero limit
    prog(8'h0F, "R9");
    for (int i = 1; i <= 5; i++) step(1, 1, (i == 4), 0, 8'h00, "R9");
    idle(2, "R9");

    // R10: saturation beyond 255 clocks
    prog(8'hF0, "R10");
    for (int i = 1; i <= 300; i++) step(1, 0, 0, 0, 8'h00, "R10");
    step(1, 1, 0, 0, 8'h00, "R10");
    for (int i = 1; i <= 3; i++) step(1, 0, (i == 3), 0, 8'h00, "R10");
    idle(2, "R10");

    // R3: a one-cycle frame gap restarts the count
    prog(8'h10, "R3");
    for (int i = 1; i <= 10; i++) step(1, 1, 0, 0, 8'h00, "R3");
    idle(1, "R3");
    for (int i = 1; i <= 10; i++) step(1, 1, 0, 0, 8'h00, "R3");
    idle(2, "R3");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule